// File: doc/BRIEF.md
# Interrupt Flag and Request Controller

This block keeps three sticky event flags for a network controller and drives an active-low interrupt request pin from them. The flags record a receive error, a transmit error and the end of a transmission. The receive and transmit engines report each event with a single-cycle set strobe. A transmit error always counts as the end of a transmission too, so it sets both transmit flags at once.

The host reaches the block through a small command port. One command writes the enable register. That register holds one enable per source and a global enable. A second command clears flag bits under a mask. The flags are always visible on a read port, so the host can poll a source whose interrupt is masked. The receive-error and transmit-done sources give level requests that last as long as their flag is set. The transmit-error source gives a low pulse one clock long, timed by a two-state pin machine. The states are IDLE and PULSE. IDLE moves to PULSE on an enabled transmit-error strobe. PULSE stays in PULSE on another enabled strobe. PULSE returns to IDLE otherwise.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset all flags and enables are 0 and `int_n_o` is 1.
- R2: A set strobe makes its flag read 1 from the next cycle. The flag then stays 1 until a clear command names it. Flag bit positions are: bit 0 transmit done, bit 1 transmit error, bit 2 receive error.
- R3: A transmit-error strobe sets both the transmit-error flag and the transmit-done flag in the same cycle.
- R4: A clear command (`cmd_op_i` = 2) clears exactly the flags whose bit in `cmd_data_i[2:0]` is 1. Other flags are left as they are.
- R5: When a set strobe and a clear of the same flag fall in the same cycle, the flag ends up 1.
- R6: An enable write (`cmd_op_i` = 1) loads `cmd_data_i[3:0]` into the enable register. Bit 0 enables transmit done, bit 1 transmit error, bit 2 receive error, and bit 3 is the global enable. `int_n_o` is 0 whenever the global enable is set and the receive-error or transmit-done flag is 1 with its own enable set.
- R7: With a source enable or the global enable at 0, that source never pulls `int_n_o` low, and its flag still reads normally.
- R8: A transmit-error strobe drives `int_n_o` low for exactly the next cycle if, before that edge, the transmit-error enable and the global enable were both 1. This holds unless a level source also holds the pin low.
- R9: An enable write leaves the flags unchanged. A clear command leaves the enables unchanged. Command codes 0 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_err_set_i | input | 1 | Receive-error event strobe |
| tx_err_set_i | input | 1 | Transmit-error event strobe |
| tx_done_set_i | input | 1 | Transmit-done event strobe |
| cmd_op_i | input | 2 | Host command: 0 none, 1 write enables, 2 clear flags, 3 none |
| cmd_data_i | input | 4 | Enable value or clear mask |
| flags_o | output | 3 | Flag read port |
| int_n_o | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach from the ports is a cycle where several things happen at the same edge. Examples are a transmit-error strobe arriving with an enable write that turns the global enable off, or a clear mask landing on a flag while its strobe fires. Random stimulus alone rarely lines these up with the right enable state. So directed steps first build each enable state and then fire the strobe and the command together. Random cycles follow with a strobe rate high enough that such collisions come up often.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
    localparam int NUM_SRC = 3;
    localparam int EN_W    = NUM_SRC + 1;
    localparam int SRC_TX_DONE = 0;
    localparam int SRC_TX_ERR  = 1;
    localparam int SRC_RX_ERR  = 2;
    localparam int EN_GLOBAL   = NUM_SRC;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_SET_EN = 2'd1,
        CMD_CLEAR  = 2'd2,
        CMD_RSVD   = 2'd3
    } cmd_op_e;

    typedef enum logic {
        PIN_IDLE  = 1'b0,
        PIN_PULSE = 1'b1
    } pin_state_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] flags_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flag_q <= 1'b0;
            else if (set_i[g])
                flag_q <= 1'b1;          // set beats a clear in the same cycle
            else if (clr_i[g])
                flag_q <= 1'b0;
        end
        assign flags_o[g] = flag_q;
    end
endmodule

// File: rtl/irq_pulse_fsm.sv
module irq_pulse_fsm
    import irq_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trigger_i,
    output logic pulse_o
);
    pin_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_IDLE:  if (trigger_i) state_d = PIN_PULSE;
            PIN_PULSE: state_d = trigger_i ? PIN_PULSE : PIN_IDLE;
            default:   state_d = PIN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PIN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pulse_o = (state_q == PIN_PULSE);
    end
endmodule

// File: rtl/irq_request_merge.sv
module irq_request_merge
    import irq_flag_pkg::*;
(
    input  logic [NUM_SRC-1:0] flags_i,
    input  logic [EN_W-1:0]    en_i,
    input  logic               pulse_i,
    output logic               int_n_o
);
    logic level_req;
    always_comb begin
        level_req = en_i[EN_GLOBAL] &
                    ((flags_i[SRC_RX_ERR]  & en_i[SRC_RX_ERR]) |
                     (flags_i[SRC_TX_DONE] & en_i[SRC_TX_DONE]));
        int_n_o = ~(level_req | pulse_i);
    end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_flag_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_err_set_i,
    input  logic                tx_err_set_i,
    input  logic                tx_done_set_i,
    input  logic [1:0]          cmd_op_i,
    input  logic [EN_W-1:0]     cmd_data_i,
    output logic [NUM_SRC-1:0]  flags_o,
    output logic                int_n_o
);
    logic [EN_W-1:0]    en_q;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic               pulse_trig;
    logic               pulse_active;
    cmd_op_e            op;

    always_comb begin
        op = cmd_op_e'(cmd_op_i);
        set_vec = '0;
        set_vec[SRC_RX_ERR]  = rx_err_set_i;
        set_vec[SRC_TX_ERR]  = tx_err_set_i;
        set_vec[SRC_TX_DONE] = tx_done_set_i | tx_err_set_i;
        clr_vec = (op == CMD_CLEAR) ? cmd_data_i[NUM_SRC-1:0] : '0;
        pulse_trig = tx_err_set_i & en_q[SRC_TX_ERR] & en_q[EN_GLOBAL];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 en_q <= '0;
        else if (op == CMD_SET_EN)  en_q <= cmd_data_i;
    end

    irq_flag_bank #(.WIDTH(NUM_SRC)) u_bank (
        .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .flags_o(flags_o)
    );

    irq_pulse_fsm u_pulse (
        .clk(clk), .rst_n(rst_n), .trigger_i(pulse_trig), .pulse_o(pulse_active)
    );

    irq_request_merge u_merge (
        .flags_i(flags_o), .en_i(en_q), .pulse_i(pulse_active), .int_n_o(int_n_o)
    );
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk
    import irq_flag_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               rx_err_set_i,
    input logic               tx_err_set_i,
    input logic [1:0]         cmd_op_i,
    input logic [EN_W-1:0]    cmd_data_i,
    input logic [NUM_SRC-1:0] flags_o,
    input logic [EN_W-1:0]    en_q,
    input logic               int_n_o
);
    logic [NUM_SRC-1:0] keep;
    always_comb keep = flags_o & ~((cmd_op_i == 2'd2) ? cmd_data_i[NUM_SRC-1:0] : '0);

    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_o & $past(keep)) == $past(keep)));
    p_txerr_both_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err_set_i |=> (flags_o[SRC_TX_ERR] && flags_o[SRC_TX_DONE]));
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err_set_i |=> flags_o[SRC_RX_ERR]);
    p_no_irq_without_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o == '0) |-> int_n_o);
    p_txerr_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_err_set_i && en_q[SRC_TX_ERR] && en_q[EN_GLOBAL]) |=> !int_n_o);
    p_en_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op_i != 2'd1) |=> $stable(en_q));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_err_set_i(rx_err_set_i), .tx_err_set_i(tx_err_set_i),
    .cmd_op_i(cmd_op_i), .cmd_data_i(cmd_data_i), .flags_o(flags_o), .en_q(en_q),
    .int_n_o(int_n_o)
);

// File: tb/irq_flag_ctrl_bench.sv
`timescale 1ns/1ps
module irq_flag_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_s = 1'b0, txe_s = 1'b0, txd_s = 1'b0;
    logic [1:0] op = 2'd0;
    logic [3:0] data = 4'd0;
    logic [2:0] flags;
    logic       int_n;

    int checks = 0;
    int fails  = 0;
    logic [2:0] m_flags = 3'd0;
    logic [3:0] m_en = 4'd0;
    logic       m_pulse = 1'b0;

    always #2 clk = ~clk;

    irq_flag_ctrl u_irq_flag_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_err_set_i(rx_s), .tx_err_set_i(txe_s),
        .tx_done_set_i(txd_s), .cmd_op_i(op), .cmd_data_i(data),
        .flags_o(flags), .int_n_o(int_n)
    );

    function automatic logic exp_int_n(input logic [2:0] f, input logic [3:0] e, input logic p);
        return !((e[3] & ((f[2] & e[2]) | (f[0] & e[0]))) | p);
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic rx, input logic te, input logic td,
                        input logic [1:0] o, input logic [3:0] d, input string tag);
        @(negedge clk);
        rx_s = rx; txe_s = te; txd_s = td; op = o; data = d;
        m_pulse = te & m_en[1] & m_en[3];
        m_flags = (m_flags & ~((o == 2'd2) ? d[2:0] : 3'd0)) | {rx, te, td | te};
        if (o == 2'd1) m_en = d;
        @(posedge clk);
        #1;
        check({tag, " flags"}, {1'b0, flags}, {1'b0, m_flags});
        check({tag, " int_n"}, {3'b0, int_n}, {3'b0, exp_int_n(m_flags, m_en, m_pulse)});
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 flags", {1'b0, flags}, 4'd0);
        check("R1 int_n", {3'b0, int_n}, 4'd1);
        rst_n = 1'b1;
        // R9: enable write with all off keeps flags zero
        step(0, 0, 0, 2'd1, 4'b0000, "R9");
        // R2/R7: rx error sets flag, masked so no interrupt
        step(1, 0, 0, 2'd0, 4'd0, "R2 R7");
        step(0, 0, 0, 2'd3, 4'hF, "R2 R9");
        // R6: enable rx source and global -> level low
        step(0, 0, 0, 2'd1, 4'b1100, "R6");
        // R4: clear rx flag -> pin releases
        step(0, 0, 0, 2'd2, 4'b0100, "R4");
        // R8: tx error enabled -> one cycle pulse, tx_done masked
        step(0, 0, 0, 2'd1, 4'b1010, "R8 setup");
        step(0, 1, 0, 2'd0, 4'd0, "R3 R8");
        step(0, 0, 0, 2'd0, 4'd0, "R8 end");
        // R5: set and clear of the same flag together
        step(0, 1, 0, 2'd2, 4'b0011, "R5");
        // R8 edge: event with global turned off at same edge still pulses
        step(0, 1, 0, 2'd1, 4'b0010, "R8 old enables");
        step(0, 0, 0, 2'd0, 4'd0, "R7 global off");
        // R9: clear keeps enables (re-enable global only after)
        step(0, 0, 0, 2'd2, 4'b0111, "R9 clear");
        step(0, 0, 1, 2'd1, 4'b1001, "R6 tx done level");
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] o;
            o = 2'($urandom_range(0, 3));
            step(($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0),
                 ($urandom_range(0, 5) == 0), o, 4'($urandom), "R2 R4 R6 random");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule